// File: doc/BRIEF.md
# DMA Page Translator

This block sits between the DMA channels and the memory system and turns a 24-bit logical DMA address into a physical memory address. The mapping is held in a page table in memory, which software builds. Pages are 4 KB. The upper part of the logical address selects a table entry. The physical frame read from that entry is joined with the untouched low 12 bits to form the physical address.

Software sets up the block by writing three locations. One holds the physical start address of the table. One holds the table size in bytes. The third is a strobe: any write to it throws away every remembered translation. The block keeps the four most recent translations in a small fully associative store. A repeated page is answered in one cycle. A new page costs one read of the table through a single-beat memory read port.

A request can fail for several reasons: the logical address lies beyond the 16 MB window, the entry lies past the table size, or the frame read back lies beyond the 512 MB physical window. In each case the block answers with a fault and keeps the offending logical address visible until the next fault.

Top module: `dma_page_xlate`

## Requirements
- R1: A translated address is the frame held in bits 28..12 of the entry's first 32-bit word, followed by logical bits 11..0 unchanged; bits 11..0 of that word are ignored and bits 31..29 of the result are zero.
- R2: A logical address with any bit above bit 23 set is answered with a fault one cycle after acceptance, with no table read.
- R3: When the entry's byte offset (page index times 8) is equal to or greater than the size register, the request faults one cycle after acceptance with no table read; after reset the size is 0, so every request faults.
- R4: A miss issues exactly one single-cycle table read at table start plus page index times 8, and the response appears in the cycle after the read data is returned.
- R5: A request whose page is held in the translation store is answered in the cycle after acceptance, with no table read.
- R6: A frame word with any of bits 31..29 set yields a fault, and that translation is not stored, so a repeat of that page reads the table again.
- R7: The fault address output takes the logical address of each faulting request, as the fault response appears. It keeps its value across successful translations and resets to 0.
- R8: A write with select code 2 (invalidate) empties the translation store. A request accepted in the same cycle misses. A table read in flight when the strobe arrives still returns its answer, but the result is not stored.
- R9: The store holds four pages and replaces them in strict rotation, one step per stored translation. The rotation position is not reset by invalidate.
- R10: Writes with select code 0 (table start) or 1 (table size) do not empty the store. The size check is still applied to pages that are held in the store.
- R11: The block accepts requests only while no table read is pending. Each response is a single-cycle pulse, and a fault response carries a physical address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 table start, 1 table size, 2 invalidate, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_laddr | input | 32 | Logical address to translate |
| resp_valid | output | 1 | Single-cycle response pulse |
| resp_fault | output | 1 | Response is a fault |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| fault_laddr | output | 32 | Logical address of the most recent fault |
| mem_req | output | 1 | Single-cycle table read request |
| mem_addr | output | 32 | Byte address of the table word to read |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table read data (frame word) |

## Verification
The bench goes after replacement order. It fills the store past its four slots, both before and after an invalidate. A design that rotates wrongly, or rewinds its pointer on invalidate, then shows a hit where a miss is due, or the other way round. It pulses invalidate in the same cycle as a lookup and again while a table read is in flight. A design that lets either race through would serve a stale frame once the table changes. It also moves the table start and lowers the size while pages are held. A design that flushes on those writes, or skips the size check on hits, then gives the wrong latency or misses a fault. Bad frame words, the last legal index, and addresses just past the 16 MB window cover the fault paths and the fault address register.

// File: rtl/dpx_pkg.sv
// Package: shared address geometry and encodings for the DMA page translator.
// Assumes 32-bit bus addresses; the per-instance widths are top-level parameters.
package dpx_pkg;

    // Selects carried on cfg_sel.
    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_INVAL = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;

    // Control states of the miss path.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

endpackage

// File: rtl/dpx_range_check.sv
// Module: dpx_range_check
// Purely combinational. From the page-number part of a logical address it
// derives the table index, the byte address of the entry and two fault
// conditions: the address lies outside the logical window, or the entry
// lies past the programmed table size. Assumes power-of-two entry size.
module dpx_range_check #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int LOG_BITS    = 24,
    parameter int ENTRY_SHIFT = 3,
    localparam int IDX_W      = LOG_BITS - PAGE_BITS
) (
    input  logic [ADDR_W-PAGE_BITS-1:0] page_num,
    input  logic [ADDR_W-1:0]           tbl_base,
    input  logic [ADDR_W-1:0]           tbl_limit,
    output logic [IDX_W-1:0]            idx,
    output logic [ADDR_W-1:0]           entry_addr,
    output logic                        out_of_space,
    output logic                        over_limit
);

    logic [ADDR_W-1:0] entry_off;

    // Split the page number into window check and table index.
    always_comb begin
        out_of_space = |page_num[ADDR_W-PAGE_BITS-1:IDX_W];
        idx          = page_num[IDX_W-1:0];
        entry_off    = ADDR_W'({idx, {ENTRY_SHIFT{1'b0}}});
        over_limit   = (entry_off >= tbl_limit);
        entry_addr   = tbl_base + entry_off;
    end

endmodule

// File: rtl/dpx_xlate_cache.sv
// Module: dpx_xlate_cache
// Small fully associative store of recent translations. Lookup is
// combinational; fills go to the slot named by a rotating pointer, which
// advances once per fill and is untouched by flush. Assumes the caller
// never fills an index that is already present.
module dpx_xlate_cache #(
    parameter int WAYS    = 4,
    parameter int IDX_W   = 12,
    parameter int FRAME_W = 17,
    localparam int PTR_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               flush
);

    logic [WAYS-1:0]    vld;
    logic [WAYS-1:0]    match;
    logic [IDX_W-1:0]   tag_q [WAYS];
    logic [FRAME_W-1:0] frm_q [WAYS];
    logic [PTR_W-1:0]   ptr_q;

    // Per-slot tag compare.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = vld[w] && (tag_q[w] == lk_idx);
    end

    // Merge the matching slot's frame (at most one slot matches).
    always_comb begin
        lk_frame = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) lk_frame = lk_frame | frm_q[w];
        end
        lk_hit = |match;
    end

    // Valid bits and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[ptr_q] <= 1'b1;
            ptr_q      <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Tag and frame storage, written only on fill.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[ptr_q] <= fill_idx;
            frm_q[ptr_q] <= fill_frame;
        end
    end

endmodule

// File: rtl/dma_page_xlate.sv
// Module: dma_page_xlate
// Translates logical DMA addresses to physical ones via a page table in
// memory. Holds table start/size registers and an invalidate strobe,
// answers held pages in one cycle, and fetches the frame word of a new page
// through a single-beat read port. Assumes the memory returns exactly one
// mem_rvalid pulse per mem_req and never without one.
module dma_page_xlate #(
    parameter int WAYS        = 4,
    parameter int ADDR_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int LOG_BITS    = 24,
    parameter int PHYS_BITS   = 29,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [ADDR_W-1:0] fault_laddr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata
);
    import dpx_pkg::*;

    localparam int IDX_W   = LOG_BITS - PAGE_BITS;
    localparam int FRAME_W = PHYS_BITS - PAGE_BITS;
    localparam int HI_W    = ADDR_W - PHYS_BITS;

    cfg_sel_e           sel;
    xl_state_e          state_q;
    logic [ADDR_W-1:0]  base_q, limit_q;
    logic               inval_now, accept, hit_now, frame_ok, stale_q, fill_en;
    logic [IDX_W-1:0]   rc_idx;
    logic [ADDR_W-1:0]  rc_eaddr;
    logic               rc_oos, rc_over;
    logic               lk_hit;
    logic [FRAME_W-1:0] lk_frame;
    logic [LOG_BITS-1:0] pend_laddr;
    logic [ADDR_W-1:0]  pend_eaddr;
    logic               resp_valid_q, resp_fault_q;
    logic [ADDR_W-1:0]  resp_paddr_q, fault_q;
    logic               frame_lsb_unused;

    assign sel              = cfg_sel_e'(cfg_sel);
    assign inval_now        = cfg_we && (sel == CFG_INVAL);
    assign req_ready        = (state_q == ST_IDLE);
    assign accept           = req_valid && req_ready;
    assign hit_now          = lk_hit && !inval_now;
    assign frame_ok         = ~|mem_rdata[ADDR_W-1:PHYS_BITS];
    assign frame_lsb_unused = ^mem_rdata[PAGE_BITS-1:0];
    assign mem_req          = (state_q == ST_ISSUE);
    assign mem_addr         = pend_eaddr;
    assign fill_en          = (state_q == ST_WAIT) && mem_rvalid && frame_ok
                              && !stale_q && !inval_now;

    assign resp_valid  = resp_valid_q;
    assign resp_fault  = resp_fault_q;
    assign resp_paddr  = resp_paddr_q;
    assign fault_laddr = fault_q;

    dpx_range_check #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .LOG_BITS   (LOG_BITS),
        .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_range (
        .page_num    (req_laddr[ADDR_W-1:PAGE_BITS]),
        .tbl_base    (base_q),
        .tbl_limit   (limit_q),
        .idx         (rc_idx),
        .entry_addr  (rc_eaddr),
        .out_of_space(rc_oos),
        .over_limit  (rc_over)
    );

    dpx_xlate_cache #(
        .WAYS   (WAYS),
        .IDX_W  (IDX_W),
        .FRAME_W(FRAME_W)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (rc_idx),
        .lk_hit    (lk_hit),
        .lk_frame  (lk_frame),
        .fill_en   (fill_en),
        .fill_idx  (pend_laddr[LOG_BITS-1:PAGE_BITS]),
        .fill_frame(mem_rdata[PHYS_BITS-1:PAGE_BITS]),
        .flush     (inval_now)
    );

    // Table start and size registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (cfg_we) begin
            case (sel)
                CFG_BASE:  base_q  <= cfg_wdata;
                CFG_LIMIT: limit_q <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    // Request sequencing, miss fetch and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            resp_valid_q <= 1'b0;
            resp_fault_q <= 1'b0;
            resp_paddr_q <= '0;
            fault_q      <= '0;
            pend_laddr   <= '0;
            pend_eaddr   <= '0;
            stale_q      <= 1'b0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (rc_oos || rc_over) begin
                            resp_valid_q <= 1'b1;
                            resp_fault_q <= 1'b1;
                            resp_paddr_q <= '0;
                            fault_q      <= req_laddr;
                        end else if (hit_now) begin
                            resp_valid_q <= 1'b1;
                            resp_fault_q <= 1'b0;
                            resp_paddr_q <= {{HI_W{1'b0}}, lk_frame,
                                             req_laddr[PAGE_BITS-1:0]};
                        end else begin
                            pend_laddr <= req_laddr[LOG_BITS-1:0];
                            pend_eaddr <= rc_eaddr;
                            stale_q    <= 1'b0;
                            state_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (inval_now) stale_q <= 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (inval_now) stale_q <= 1'b1;
                    if (mem_rvalid) begin
                        state_q      <= ST_IDLE;
                        resp_valid_q <= 1'b1;
                        if (frame_ok) begin
                            resp_fault_q <= 1'b0;
                            resp_paddr_q <= {{HI_W{1'b0}},
                                             mem_rdata[PHYS_BITS-1:PAGE_BITS],
                                             pend_laddr[PAGE_BITS-1:0]};
                        end else begin
                            resp_fault_q <= 1'b1;
                            resp_paddr_q <= '0;
                            fault_q      <= ADDR_W'(pend_laddr);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dpx_checker.sv
// Module: dpx_checker
// Protocol properties of the translator's ports, bound to every instance.
module dpx_checker #(
    parameter int ADDR_W    = 32,
    parameter int PHYS_BITS = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic [ADDR_W-1:0] fault_laddr,
    input logic              mem_req
);

    a_r4_fetch_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r11_busy_while_fetching: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r11_fault_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    a_r11_ready_with_response: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    a_r1_phys_window: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[ADDR_W-1:PHYS_BITS] == '0));

    a_r7_fault_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_fault) |-> $stable(fault_laddr));

endmodule

bind dma_page_xlate dpx_checker #(
    .ADDR_W   (ADDR_W),
    .PHYS_BITS(PHYS_BITS)
) u_dpx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .fault_laddr(fault_laddr),
    .mem_req    (mem_req)
);

// File: tb/dma_page_xlate_test.sv
module dma_page_xlate_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        resp_valid, resp_fault;
    logic [31:0] resp_paddr, fault_laddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int mem_cnt = 0;
    int resp_seen = 0;
    int resp_exp = 0;
    logic [31:0] last_mem_addr = '0;

    // memory model state
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] tbl [int];

    // reference model state
    logic [31:0] base_m = '0, limit_m = '0, fault_m = '0;
    bit          mv [4];
    int          mtag [4];
    logic [16:0] mfrm [4];
    int          mptr = 0;

    dma_page_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .fault_laddr(fault_laddr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        if (tbl.exists(int'(a))) return tbl[int'(a)];
        return ((a * 32'h0000_0a37) ^ 32'h0135_7abc) & 32'h1FFF_FFFF;
    endfunction

    // Memory: fixed latency, one data pulse per request.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= tbl_word(pend_addr);
            end
        end
        if (mem_req) begin
            pend_addr <= mem_addr;
            pend_cnt  <= MEM_LAT;
            mem_cnt++;
            last_mem_addr = mem_addr;
        end
        if (rst_n && resp_valid) resp_seen++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "WD", "watchdog expired", cyc, 0);
            finish_run();
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
        if (sel == 2'd0) base_m = d;
        else if (sel == 2'd1) limit_m = d;
        else if (sel == 2'd2) foreach (mv[i]) mv[i] = 0;
    endtask

    task automatic m_install(input int idx, input logic [16:0] f);
        mv[mptr] = 1; mtag[mptr] = idx; mfrm[mptr] = f;
        mptr = (mptr + 1) % 4;
    endtask

    // One translation against the behavioural model.
    task automatic xlate(input logic [31:0] la, input string req,
                         input bit inv_same = 0, input bit inv_mid = 0);
        int idx = int'(la[23:12]);
        logic [31:0] off = 32'(idx) * 8;
        bit fetch = 0, fault = 0, hit = 0;
        logic [31:0] pa = '0, ea = '0, w;
        int c0 = mem_cnt, lat = 1;
        if (inv_same) foreach (mv[i]) mv[i] = 0;
        if (la > 32'h00FF_FFFF) fault = 1;
        else if (off >= limit_m) fault = 1;
        else begin
            for (int i = 0; i < 4; i++)
                if (mv[i] && mtag[i] == idx) begin
                    hit = 1; pa = {3'b0, mfrm[i], la[11:0]};
                end
            if (!hit) begin
                fetch = 1; ea = base_m + off; w = tbl_word(ea);
                if (inv_mid) foreach (mv[i]) mv[i] = 0;
                if (w[31:29] != 0) fault = 1;
                else begin
                    pa = {3'b0, w[28:12], la[11:0]};
                    if (!inv_mid) m_install(idx, w[28:12]);
                end
            end
        end
        if (fault) begin pa = '0; fault_m = la; end
        resp_exp++;

        req_valid = 1'b1; req_laddr = la;
        if (inv_same) begin cfg_we = 1'b1; cfg_sel = 2'd2; end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd3;
        if (inv_mid) begin cfg_we = 1'b1; cfg_sel = 2'd2; end
        while (!resp_valid && lat < 40) begin
            @(negedge clk);
            cfg_we = 1'b0; cfg_sel = 2'd3;
            lat++;
        end
        cfg_we = 1'b0; cfg_sel = 2'd3;
        check(resp_valid, req, "response present", 32'(resp_valid), 1);
        check(resp_fault == fault, req, "fault flag", 32'(resp_fault), 32'(fault));
        check(resp_paddr == pa, req, "physical address", resp_paddr, pa);
        check((lat == 1) == !fetch, req, "latency class", lat, fetch ? 5 : 1);
        check(mem_cnt - c0 == int'(fetch), req, "table reads", mem_cnt - c0, 32'(fetch));
        if (fetch) check(last_mem_addr == ea, req, "table read address", last_mem_addr, ea);
        check(fault_laddr == fault_m, req, "fault address", fault_laddr, fault_m);
        @(negedge clk);
        check(!resp_valid && resp_seen == resp_exp, req, "single response pulse",
              resp_seen, resp_exp);
    endtask

    initial begin
        foreach (mv[i]) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(req_ready && !resp_valid && !mem_req, "R11", "reset handshake",
              {29'b0, req_ready, resp_valid, mem_req}, 32'h4);
        check(fault_laddr == 0, "R7", "reset fault address", fault_laddr, 0);

        // R3: size is 0 after reset
        xlate(32'h0000_1000, "R3");

        cfg_write(2'd0, 32'h0010_0000);
        cfg_write(2'd1, 32'h0000_8000);
        // R4 miss then R5 hit, R1 offsets
        xlate(32'h0000_0123, "R4");
        xlate(32'h0000_0FFF, "R5");
        xlate(32'h0000_0000, "R1");
        // R2 window
        xlate(32'h0100_0000, "R2");
        xlate(32'hFFFF_FFFF, "R2");
        xlate(32'h00FF_FFFF, "R1");
        // R9 rotation
        xlate(32'h0000_1010, "R9");
        xlate(32'h0000_2020, "R9");
        xlate(32'h0000_3030, "R9");
        xlate(32'h0000_4040, "R9");
        xlate(32'h0000_2222, "R9");
        xlate(32'h0000_1111, "R9");
        xlate(32'h0000_3333, "R9");
        // R6 bad frame not cached
        tbl[int'(32'h0010_0000 + 5*8)] = 32'h4000_1000;
        xlate(32'h0000_5abc, "R6");
        xlate(32'h0000_5abc, "R6");
        xlate(32'h0000_4444, "R7");
        // R8 invalidate
        cfg_write(2'd2, 32'h0);
        xlate(32'h0000_4444, "R8");
        xlate(32'h0000_4444, "R8", 1, 0);
        xlate(32'h0000_7007, "R8", 0, 1);
        xlate(32'h0000_7007, "R8");
        tbl[int'(32'h0010_0000 + 7*8)] = 32'h0ABC_D000;
        xlate(32'h0000_7007, "R8");
        cfg_write(2'd2, 32'h0);
        xlate(32'h0000_7007, "R8");
        // R9 pointer survives invalidate
        cfg_write(2'd2, 32'h0);
        for (int p = 10; p < 15; p++) xlate(32'(p) << 12, "R9");
        for (int p = 10; p < 15; p++) xlate((32'(p) << 12) | 32'h55, "R9");
        // R10 start/size writes keep the store
        xlate(32'h0000_2002, "R10");
        xlate(32'h0000_3003, "R10");
        cfg_write(2'd0, 32'h0020_0000);
        xlate(32'h0000_2002, "R10");
        cfg_write(2'd1, 32'h0000_0018);
        xlate(32'h0000_3003, "R10");
        xlate(32'h0000_2004, "R10");
        cfg_write(2'd1, 32'h0000_8000);
        cfg_write(2'd2, 32'h0);
        xlate(32'h0000_2002, "R10");
        // R3 last index boundary
        xlate(32'h00FF_F123, "R3");
        cfg_write(2'd1, 32'h0000_7FF8);
        xlate(32'h00FF_F123, "R3");
        xlate(32'h00FF_E001, "R3");

        finish_run();
    end

endmodule